// File: doc/BRIEF.md
# Width-Adapting Single DMA Channel

This block is one DMA channel. It moves a programmed number of data items from a source address to a destination address through a 32-bit read/write bus master port. Each item takes two bus beats: a read at the source width, then a write at the destination width. When the destination is wider than the source, the value is zero-extended. When it is narrower, the value is truncated to its low bits. Sub-word writes repeat the data on every byte lane, so a slave that only accepts full words still stores the right bytes.

The channel takes a register-style set of configuration inputs. These are enable, memory-to-memory mode, circular mode, per-side increment flags, per-side size codes, item count and the two base addresses. The channel captures them when the enable input rises. In memory-to-memory mode the channel runs on its own. Otherwise it moves one item for each peripheral request and answers each request with a one-cycle acknowledge. A one-cycle completion pulse marks the end of the last item. Circular mode reloads the count and both addresses and keeps going.

Top module: `dma_xlate_chan`

## Requirements
- R1: In memory-to-memory mode the channel begins bus reads after the enable input rises. It needs no peripheral request and moves all programmed items back to back.
- R2: Exactly the programmed number of items is moved. Each item is one read beat and one write beat. No further beat is issued after the remaining count reaches zero, even with the request held high.
- R3: Memory-to-memory and circular modes enabled together are invalid, and so is the reserved size code 3 on either side. With such a configuration, cfg_err is high one cycle after the enable and configuration are present, and no bus beat is issued. cfg_err drops one cycle after the enable is cleared.
- R4: Each write beat follows the read beat of the same item. While bus_valid is high and bus_ready is low, the beat's address, direction, size and write data hold steady. After reset the bus is idle and all pulse outputs are low.
- R5: When the destination is wider than the source, the written item holds the read value in its low bits and zeros above.
- R6: When the destination is narrower than the source, the written item holds only the low bits of the read value. Read data is taken little-endian from the byte lanes selected by the low address bits: lane n is bits 8n+7..8n.
- R7: Size codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. With incrementing on, the source address advances by the source size in bytes after each item, and the destination address advances by the destination size.
- R8: A byte write repeats the byte on all four lanes of bus_wdata. A halfword write repeats the halfword in both halves.
- R9: A side whose increment flag is clear uses its base address for every item.
- R10: In request-driven mode no beat starts without periph_req. Each request moves exactly one item, and periph_ack pulses for one cycle in the cycle after the write handshake.
- R11: In circular mode, after the last item the count and both addresses reload from the captured values, and the transfer continues on later requests.
- R12: xfer_done pulses for exactly one cycle, in the cycle after the write handshake of the last item of a run.
- R13: Clearing the enable during a beat lets that beat finish. If the beat was a read, no write follows, and no further beat is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Channel enable; a rising edge captures the configuration |
| cfg_m2m | input | 1 | Memory-to-memory (self-running) mode |
| cfg_circ | input | 1 | Circular reload mode |
| cfg_src_inc | input | 1 | Source address increments per item |
| cfg_dst_inc | input | 1 | Destination address increments per item |
| cfg_src_size | input | 2 | Source size code (0: 8, 1: 16, 2: 32 bits) |
| cfg_dst_size | input | 2 | Destination size code |
| cfg_count | input | CW | Number of items |
| cfg_src_addr | input | AW | Source base address |
| cfg_dst_addr | input | AW | Destination base address |
| periph_req | input | 1 | Peripheral request for one item |
| periph_ack | output | 1 | One-cycle acknowledge after an item's write |
| bus_valid | output | 1 | Bus beat pending |
| bus_write | output | 1 | Beat direction, 1 for write |
| bus_addr | output | AW | Byte address of the beat |
| bus_size | output | 2 | Size code of the beat |
| bus_wdata | output | DW | Write data with lane replication |
| bus_ready | input | 1 | Beat completes at a clock edge where valid and ready are both high |
| bus_rdata | input | DW | Read data, valid with bus_ready on a read |
| xfer_done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Invalid configuration flag |

## Verification
All nine source/destination width pairs are swept with incrementing addresses, bus wait states that vary from run to run, and destination memory pre-filled with non-zero bytes. This separates zero-extension, truncation and per-side address stepping, and byte-lane extraction is exercised at every offset. Runs with fixed addresses at an odd source offset separate the increment flags from the stride logic. Request-driven runs with the request held idle, then pulsed, then held past the count separate one-item-per-request from free running. Circular, invalid-configuration and mid-read abort runs show reload order, refusal to start, and the stop at a beat boundary.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xsize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xstate_e;

  function automatic logic size_is_bad(input logic [1:0] code);
    return code == SZ_RSVD;
  endfunction

endpackage

// File: rtl/dma_xlate_addr.sv
module dma_xlate_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rewind,
  input  logic          step,
  input  logic          inc,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] stride;

  assign stride = AW'(1) << size;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr   <= '0;
    end else if (start) begin
      base_q <= base_in;
      addr   <= base_in;
    end else if (rewind) begin
      addr <= base_q;
    end else if (step && inc) begin
      addr <= addr + stride;
    end
  end

endmodule

// File: rtl/dma_xlate_fmt.sv
module dma_xlate_fmt #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rd_word,
  input  logic [1:0]    lane,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  output logic [DW-1:0] wr_word
);

  localparam int LANES = DW / 8;
  localparam int HALVES = LANES / 2;

  logic [DW-1:0] shifted;
  logic [DW-1:0] item;

  assign shifted = rd_word >> {lane, 3'b000};

  // source side: keep only the bits of the source width
  always_comb begin
    case (src_size)
      2'd0:    item = {{(DW-8){1'b0}}, shifted[7:0]};
      2'd1:    item = {{(DW-16){1'b0}}, shifted[15:0]};
      default: item = shifted;
    endcase
  end

  // destination side: truncate or keep, then repeat across lanes
  always_comb begin
    case (dst_size)
      2'd0:    wr_word = {LANES{item[7:0]}};
      2'd1:    wr_word = {HALVES{item[15:0]}};
      default: wr_word = item;
    endcase
  end

endmodule

// File: rtl/dma_xlate_ctl.sv
module dma_xlate_ctl
  import dma_xlate_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic          cfg_bad,
  input  logic          cfg_m2m,
  input  logic          cfg_circ,
  input  logic [CW-1:0] cfg_count,
  input  logic          periph_req,
  input  logic          bus_ready,
  output logic          start,
  output logic          rewind,
  output logic          step,
  output logic          capture,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          periph_ack,
  output logic          xfer_done
);

  xstate_e       state;
  logic          en_q;
  logic          active;
  logic          m2m_q;
  logic          circ_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_base;
  logic          rd_done;
  logic          wr_done;
  logic          last;
  logic          go;

  assign start   = (state == ST_IDLE) && cfg_en && !en_q && !cfg_bad;
  assign rd_done = (state == ST_RD) && bus_ready;
  assign wr_done = (state == ST_WR) && bus_ready;
  assign last    = (cnt == CW'(1));
  assign capture = rd_done;
  assign step    = wr_done && !(last && circ_q);
  assign rewind  = wr_done && last && circ_q;
  assign go      = active && cfg_en && !periph_ack && (m2m_q || periph_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      en_q       <= 1'b0;
      active     <= 1'b0;
      m2m_q      <= 1'b0;
      circ_q     <= 1'b0;
      cnt        <= '0;
      cnt_base   <= '0;
      bus_valid  <= 1'b0;
      bus_write  <= 1'b0;
      periph_ack <= 1'b0;
      xfer_done  <= 1'b0;
    end else begin
      en_q       <= cfg_en;
      periph_ack <= 1'b0;
      xfer_done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!cfg_en) begin
            active <= 1'b0;
          end else if (start) begin
            active   <= (cfg_count != '0);
            cnt      <= cfg_count;
            cnt_base <= cfg_count;
            m2m_q    <= cfg_m2m;
            circ_q   <= cfg_circ;
          end else if (go) begin
            state     <= ST_RD;
            bus_valid <= 1'b1;
            bus_write <= 1'b0;
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            if (!cfg_en) begin
              state     <= ST_IDLE;
              bus_valid <= 1'b0;
              active    <= 1'b0;
            end else begin
              state     <= ST_WR;
              bus_write <= 1'b1;
            end
          end
        end
        ST_WR: begin
          if (bus_ready) begin
            state      <= ST_IDLE;
            bus_valid  <= 1'b0;
            bus_write  <= 1'b0;
            periph_ack <= !m2m_q;
            if (last) begin
              xfer_done <= 1'b1;
              cnt       <= circ_q ? cnt_base : '0;
              if (!circ_q) active <= 1'b0;
            end else begin
              cnt <= cnt - CW'(1);
            end
            if (!cfg_en) active <= 1'b0;
          end
        end
        default: begin
          state     <= ST_IDLE;
          bus_valid <= 1'b0;
          bus_write <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_xlate_chan.sv
module dma_xlate_chan
  import dma_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic          cfg_m2m,
  input  logic          cfg_circ,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [1:0]    cfg_src_size,
  input  logic [1:0]    cfg_dst_size,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic          periph_req,
  output logic          periph_ack,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_done,
  output logic          cfg_err
);

  logic          cfg_bad;
  logic          start;
  logic          rewind;
  logic          step;
  logic          capture;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;
  logic [1:0]    src_size_q;
  logic [1:0]    dst_size_q;
  logic          src_inc_q;
  logic          dst_inc_q;
  logic [DW-1:0] fmt_word;
  logic [DW-1:0] wdata_q;

  assign cfg_bad = (cfg_m2m && cfg_circ) ||
                   size_is_bad(cfg_src_size) || size_is_bad(cfg_dst_size);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err    <= 1'b0;
      src_size_q <= 2'd0;
      dst_size_q <= 2'd0;
      src_inc_q  <= 1'b0;
      dst_inc_q  <= 1'b0;
      wdata_q    <= '0;
    end else begin
      cfg_err <= cfg_en && cfg_bad;
      if (start) begin
        src_size_q <= cfg_src_size;
        dst_size_q <= cfg_dst_size;
        src_inc_q  <= cfg_src_inc;
        dst_inc_q  <= cfg_dst_inc;
      end
      if (capture) wdata_q <= fmt_word;
    end
  end

  dma_xlate_ctl #(.CW(CW)) ctl_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg_en),
    .cfg_bad    (cfg_bad),
    .cfg_m2m    (cfg_m2m),
    .cfg_circ   (cfg_circ),
    .cfg_count  (cfg_count),
    .periph_req (periph_req),
    .bus_ready  (bus_ready),
    .start      (start),
    .rewind     (rewind),
    .step       (step),
    .capture    (capture),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .periph_ack (periph_ack),
    .xfer_done  (xfer_done)
  );

  dma_xlate_addr #(.AW(AW)) src_gen_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rewind  (rewind),
    .step    (step),
    .inc     (src_inc_q),
    .size    (src_size_q),
    .base_in (cfg_src_addr),
    .addr    (src_addr)
  );

  dma_xlate_addr #(.AW(AW)) dst_gen_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rewind  (rewind),
    .step    (step),
    .inc     (dst_inc_q),
    .size    (dst_size_q),
    .base_in (cfg_dst_addr),
    .addr    (dst_addr)
  );

  dma_xlate_fmt #(.DW(DW)) fmt_i (
    .rd_word  (bus_rdata),
    .lane     (src_addr[1:0]),
    .src_size (src_size_q),
    .dst_size (dst_size_q),
    .wr_word  (fmt_word)
  );

  assign bus_addr  = bus_write ? dst_addr : src_addr;
  assign bus_size  = bus_write ? dst_size_q : src_size_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_en,
  input logic          cfg_m2m,
  input logic          cfg_circ,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [DW-1:0] bus_wdata,
  input logic          periph_ack,
  input logic          xfer_done,
  input logic          cfg_err
);

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_m2m && cfg_circ) |=> cfg_err); // R3

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_write) |-> $past(bus_valid && !bus_write && bus_ready)); // R4

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) && $stable(bus_addr)
                                   && $stable(bus_size) && $stable(bus_wdata))); // R4

  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size == 2'd0) |->
      (bus_wdata[7:0] == bus_wdata[15:8] && bus_wdata[7:0] == bus_wdata[23:16]
       && bus_wdata[7:0] == bus_wdata[31:24])); // R8

  AST_HALF_LANES: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size == 2'd1) |->
      (bus_wdata[15:0] == bus_wdata[31:16])); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done); // R12

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> $past(bus_valid && bus_write && bus_ready)); // R12

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    periph_ack |-> $past(bus_valid && bus_write && bus_ready)); // R10

endmodule

bind dma_xlate_chan dma_xlate_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_en     (cfg_en),
  .cfg_m2m    (cfg_m2m),
  .cfg_circ   (cfg_circ),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_ready  (bus_ready),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_wdata  (bus_wdata),
  .periph_ack (periph_ack),
  .xfer_done  (xfer_done),
  .cfg_err    (cfg_err)
);

// File: tb/dma_xlate_chan_tb_top.sv
`timescale 1ns/1ps
module dma_xlate_chan_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_m2m = 1'b0;
  logic          cfg_circ = 1'b0;
  logic          cfg_src_inc = 1'b0;
  logic          cfg_dst_inc = 1'b0;
  logic [1:0]    cfg_src_size = 2'd0;
  logic [1:0]    cfg_dst_size = 2'd0;
  logic [CW-1:0] cfg_count = '0;
  logic [AW-1:0] cfg_src_addr = '0;
  logic [AW-1:0] cfg_dst_addr = '0;
  logic          periph_req = 1'b0;
  logic          periph_ack;
  logic          bus_valid;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          xfer_done;
  logic          cfg_err;

  always #4 clk = ~clk;

  dma_xlate_chan #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_m2m(cfg_m2m), .cfg_circ(cfg_circ),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size), .cfg_count(cfg_count),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .periph_req(periph_req), .periph_ack(periph_ack),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .xfer_done(xfer_done), .cfg_err(cfg_err)
  );

  logic [7:0] mem [0:255];
  int n_tests = 0, n_fail = 0;
  int n_rd, n_wr, n_done, n_ack, order_bad, repl_bad, stall_n, wait_cnt;
  bit last_rd;
  int rd_log [0:63];
  int wr_log [0:63];
  bit finished = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic mem_init();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  task automatic clear_stats();
    n_rd = 0; n_wr = 0; n_done = 0; n_ack = 0;
    order_bad = 0; repl_bad = 0; last_rd = 0; wait_cnt = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus responder and monitor, acting at falling edges
  initial begin
    forever begin
      @(negedge clk);
      bus_ready = 1'b0;
      if (!rst && bus_valid) begin
        if (wait_cnt >= stall_n) begin
          int a;
          wait_cnt = 0;
          bus_ready = 1'b1;
          a = int'(bus_addr[7:0]);
          if (!bus_write) begin
            int w;
            w = a & 8'hFC;
            bus_rdata = {mem[w+3], mem[w+2], mem[w+1], mem[w]};
            rd_log[n_rd % 64] = a;
            n_rd++;
            last_rd = 1;
          end else begin
            if (!last_rd) order_bad++;
            last_rd = 0;
            wr_log[n_wr % 64] = a;
            n_wr++;
            if (bus_size == 2'd0 && bus_wdata != {4{bus_wdata[7:0]}}) repl_bad++;
            if (bus_size == 2'd1 && bus_wdata != {2{bus_wdata[15:0]}}) repl_bad++;
            for (int j = 0; j < (1 << bus_size); j++)
              mem[(a + j) & 255] = bus_wdata[8*(((a & 3) + j) & 3) +: 8];
          end
        end else begin
          wait_cnt++;
        end
      end
      if (xfer_done) n_done++;
      if (periph_ack) n_ack++;
    end
  end

  task automatic set_cfg(input bit m2m, input bit circ, input bit si, input bit di,
                         input int ss, input int ds, input int cnt, input int sb, input int db);
    cfg_m2m = m2m; cfg_circ = circ; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds); cfg_count = CW'(cnt);
    cfg_src_addr = AW'(sb); cfg_dst_addr = AW'(db);
  endtask

  task automatic wait_done(input int limit);
    for (int c = 0; c < limit && n_done == 0; c++) @(negedge clk);
  endtask

  task automatic one_request(input string req);
    int c;
    periph_req = 1'b1;
    c = 0;
    do begin @(negedge clk); c++; end while (!periph_ack && c < 500);
    check(periph_ack == 1'b1, req, "request acknowledged", periph_ack, 1);
    periph_req = 1'b0;
    @(negedge clk);
    check(periph_ack == 1'b0, "R10", "ack lasts one cycle", periph_ack, 0);
  endtask

  initial begin
    stall_n = 0;
    clear_stats();
    mem_init();
    repeat (5) @(negedge clk);
    check(bus_valid == 0 && xfer_done == 0 && periph_ack == 0 && cfg_err == 0,
          "R4", "idle outputs in reset", {bus_valid, xfer_done, periph_ack, cfg_err}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R5 R6 R7 R1 R2: sweep all width pairs, memory to memory, incrementing
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 3; d++) begin
        int bad, abad, sb, db;
        sb = 16; db = 128;
        mem_init(); clear_stats();
        stall_n = (s + d) % 3;
        set_cfg(1, 0, 1, 1, s, d, 4, sb, db);
        @(negedge clk); cfg_en = 1'b1;
        wait_done(2000);
        repeat (3) @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        bad = 0; abad = 0;
        for (int k = 0; k < 4; k++) begin
          for (int j = 0; j < (1 << d); j++) begin
            logic [7:0] e;
            e = (j < (1 << s)) ? pat(sb + k * (1 << s) + j) : 8'h00;
            if (mem[db + k * (1 << d) + j] !== e) bad++;
          end
          if (rd_log[k] != sb + k * (1 << s)) abad++;
          if (wr_log[k] != db + k * (1 << d)) abad++;
        end
        if (d > s)      check(bad == 0, "R5", "zero-extended items", bad, 0);
        else if (d < s) check(bad == 0, "R6", "truncated items", bad, 0);
        else            check(bad == 0, "R7", "same-width items", bad, 0);
        check(abad == 0, "R7", "per-side address stride", abad, 0);
        check(n_rd == 4 && n_wr == 4, "R2", "beat counts (R1 no request used)", n_rd * 16 + n_wr, 68);
        check(n_done == 1, "R12", "single completion pulse", n_done, 1);
        check(order_bad == 0, "R4", "read precedes write", order_bad, 0);
        check(repl_bad == 0, "R8", "lane replication", repl_bad, 0);
      end
    end

    // R9 fixed addresses, odd source lane
    begin
      int abad;
      mem_init(); clear_stats(); stall_n = 1;
      set_cfg(1, 0, 0, 0, 0, 2, 3, 33, 132);
      @(negedge clk); cfg_en = 1'b1;
      wait_done(2000);
      repeat (3) @(negedge clk); cfg_en = 1'b0; @(negedge clk);
      abad = 0;
      for (int k = 0; k < 3; k++) begin
        if (rd_log[k] != 33) abad++;
        if (wr_log[k] != 132) abad++;
      end
      check(abad == 0 && n_rd == 3, "R9", "fixed addresses", abad, 0);
      check({mem[135], mem[134], mem[133], mem[132]} == {24'h0, pat(33)}, "R6",
            "lane 1 byte zero-extended", {mem[135], mem[134], mem[133], mem[132]}, {24'h0, pat(33)});
    end

    // R10 request-driven mode
    begin
      mem_init(); clear_stats(); stall_n = 0;
      set_cfg(0, 0, 1, 1, 1, 1, 3, 64, 160);
      @(negedge clk); cfg_en = 1'b1;
      repeat (20) @(negedge clk);
      check(n_rd == 0, "R10", "no beat without request", n_rd, 0);
      for (int i = 0; i < 3; i++) begin
        one_request("R10");
        check(n_rd == i + 1 && n_wr == i + 1, "R10", "one item per request", n_wr, i + 1);
      end
      check(n_done == 1, "R12", "done after last requested item", n_done, 1);
      periph_req = 1'b1;
      repeat (20) @(negedge clk);
      periph_req = 1'b0;
      check(n_rd == 3 && n_wr == 3, "R2", "no beat past count", n_rd, 3);
      check(repl_bad == 0, "R8", "halfword replication", repl_bad, 0);
      cfg_en = 1'b0; @(negedge clk);
    end

    // R11 circular reload
    begin
      int abad;
      mem_init(); clear_stats(); stall_n = 2;
      set_cfg(0, 1, 1, 1, 0, 0, 2, 48, 192);
      @(negedge clk); cfg_en = 1'b1; @(negedge clk);
      for (int i = 0; i < 5; i++) one_request("R11");
      abad = 0;
      for (int k = 0; k < 5; k++) begin
        if (rd_log[k] != 48 + (k % 2)) abad++;
        if (wr_log[k] != 192 + (k % 2)) abad++;
      end
      check(abad == 0, "R11", "addresses rewind after count", abad, 0);
      check(n_done == 2, "R11", "completion per lap", n_done, 2);
      cfg_en = 1'b0; @(negedge clk);
    end

    // R3 invalid configurations
    begin
      clear_stats(); stall_n = 0;
      set_cfg(1, 1, 1, 1, 0, 0, 4, 0, 128);
      @(negedge clk); cfg_en = 1'b1;
      repeat (10) @(negedge clk);
      check(cfg_err == 1 && n_rd == 0, "R3", "m2m with circular refused", {cfg_err, n_rd[3:0]}, 16);
      cfg_en = 1'b0;
      repeat (2) @(negedge clk);
      check(cfg_err == 0, "R3", "error clears with enable", cfg_err, 0);
      set_cfg(1, 0, 1, 1, 3, 0, 4, 0, 128);
      @(negedge clk); cfg_en = 1'b1;
      repeat (10) @(negedge clk);
      check(cfg_err == 1 && n_rd == 0, "R3", "reserved size refused", {cfg_err, n_rd[3:0]}, 16);
      cfg_en = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R13 abort during a read beat
    begin
      int c;
      mem_init(); clear_stats(); stall_n = 3;
      set_cfg(1, 0, 1, 1, 2, 2, 8, 0, 128);
      @(negedge clk); cfg_en = 1'b1;
      c = 0;
      do begin @(posedge clk); #2; c++; end
        while (!(n_wr == 2 && bus_valid && !bus_write) && c < 2000);
      cfg_en = 1'b0;
      repeat (30) @(negedge clk);
      check(n_rd == 3 && n_wr == 2, "R13", "read finishes, no write follows", n_rd * 16 + n_wr, 50);
      check(bus_valid == 0 && n_done == 0, "R13", "channel idle after abort", {bus_valid, n_done[3:0]}, 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule